// File: doc/BRIEF.md
# Interrupt Vector Router with Mapping and Clear Registers

The router sits beside a PCI host bridge and turns 48 level-sensitive interrupt sources into 48 interrupt-vector outputs. Sources 0 to 31 are PCI slot lines. Sources 32 to 47 are on-board I/O lines. Software reaches the block through a 32-bit register port: one write strobe and a byte address. Read data comes back combinationally from the same address.

Each PCI mapping register covers a group of four slot lines. Each on-board line has a mapping register of its own. The only writable field of a mapping register is the enable bit. The lower bits are fixed identification values that software can read back. A write to a clear register lowers one vector until its source changes level again. Only the upper 32-bit word of each 8-byte register slot responds.

A small combinational helper derives the slot line index from a device/function number and an interrupt pin. It has one formula for the primary bus and another for a secondary bus.

Top module: `irq_router`

## Requirements
- R1: Reset sets every vector output low and clears the enable bit (bit 31) of every mapping register. The fixed low bits of the mapping registers are unaffected by reset.
- R2: The PCI mapping register g (g = 0..7) is read at byte address 0x0C04 + 8*g and returns {enable, 0x7C0 | (g << 2)} in bits 31 and 10:0. The on-board mapping register k (k = 0..15) is read at 0x1004 + 8*k and returns {enable, 0x7E0 + k}.
- R3: A write to a mapping register changes only bit 31. Bits 30:0 read back the same value whatever data is written.
- R4: An access with address bit 2 clear (the even word of a slot) has no effect. A read of it returns 0, and a write to it neither changes a mapping register nor clears a vector.
- R5: PCI source n is gated by PCI mapping register n >> 2. On-board source k (vector 32 + k) is gated by on-board mapping register k.
- R6: When its gate is enabled, a vector takes the source's new level on the clock edge after the source changes level. A vector whose source has not changed keeps its value, including when the gate is switched on while the source is already high.
- R7: The clock edge after a gate's enable bit is written to 0, every vector in that group is low.
- R8: A write to 0x1404 + 8*j (j = 0..7) lowers vector j on that clock edge. A write to 0x1804 + 8*m (m = 0..11) lowers vector 32 + m on that clock edge. The vector stays low until its source changes level again.
- R9: If a clear write and a rising source level fall in the same cycle, the vector is low after that edge. It stays low while the source stays high.
- R10: The slot line index is {devfn[4:3], 2'b00} + pin on a secondary bus. On the primary bus it is pin, plus 16 when devfn bit 0 is set.
- R11: An address outside the mapping and clear ranges reads 0. A write to it changes no vector and no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 16 | Byte address of the register access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| srcLevel | input | 48 | Interrupt source levels: PCI lines 0..31, on-board lines 32..47 |
| vecOut | output | 48 | Registered interrupt-vector outputs |
| slotDevFn | input | 8 | Device/function number for the slot index helper |
| slotPin | input | 2 | Interrupt pin 0..3 for the slot index helper |
| slotPrimary | input | 1 | 1 selects the primary-bus formula |
| slotLine | output | 5 | Derived slot line index |

## Verification
The bench enables a gate while its source is already high. A router that follows the level instead of the change would raise that vector at once. A clear is written in the same cycle as a rising source level. A design that let the level win would leave the vector high. Writes of all-ones and all-zeros show whether the fixed low bits of a mapping register are writable. Clear and enable writes to the even word of a slot show whether the decoder ignores address bit 2, which would lower or enable the wrong lines.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int PCI_SRC      = 32;
  localparam int IO_SRC       = 16;
  localparam int PCI_PER_REG  = 4;
  localparam int PCI_REGS     = PCI_SRC / PCI_PER_REG;
  localparam int NUM_VEC      = PCI_SRC + IO_SRC;
  localparam int ADDR_W       = 16;
  localparam int DATA_W       = 32;
  localparam int EN_BIT       = DATA_W - 1;
  localparam int PCI_REG_IDX_W = $clog2(PCI_REGS);
  localparam int IO_IDX_W     = $clog2(IO_SRC);
  localparam int SLOT_W       = 5;
  localparam int PIN_W        = 2;
  localparam int LINE_W       = 5;

  localparam logic [ADDR_W-1:0] PCI_MAP_BASE = 16'h0C00;
  localparam logic [ADDR_W-1:0] IO_MAP_BASE  = 16'h1000;
  localparam logic [ADDR_W-1:0] PCI_CLR_BASE = 16'h1400;
  localparam logic [ADDR_W-1:0] IO_CLR_BASE  = 16'h1800;
  localparam logic [ADDR_W-1:0] IO_CLR_LAST  = 16'h1860;

  typedef struct packed {
    logic              pciMapWr;
    logic              ioMapWr;
    logic              pciClr;
    logic              ioClr;
    logic              pciMapSel;
    logic              ioMapSel;
    logic [SLOT_W-1:0] slot;
  } strobe_t;

  function automatic logic [EN_BIT-1:0] pciMapLow(input int g);
    return EN_BIT'(11'h7C0 | 11'(g << 2));
  endfunction

  function automatic logic [EN_BIT-1:0] ioMapLow(input int k);
    return EN_BIT'(11'h7E0 + 11'(k));
  endfunction
endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
(
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  logic oddWord, pciMapHit, ioMapHit, pciClrHit, ioClrHit;
  logic unusedLowAddr;

  assign unusedLowAddr = ^regAddr[1:0];
  assign oddWord   = regAddr[2];
  assign pciMapHit = regAddr[ADDR_W-1:6] == PCI_MAP_BASE[ADDR_W-1:6];
  assign ioMapHit  = regAddr[ADDR_W-1:7] == IO_MAP_BASE[ADDR_W-1:7];
  assign pciClrHit = regAddr[ADDR_W-1:6] == PCI_CLR_BASE[ADDR_W-1:6];
  assign ioClrHit  = (regAddr[ADDR_W-1:8] == IO_CLR_BASE[ADDR_W-1:8]) &&
                     (regAddr[7:0] <= IO_CLR_LAST[7:0]);

  always_comb begin
    stb.pciMapSel = oddWord && pciMapHit;
    stb.ioMapSel  = oddWord && ioMapHit;
    stb.pciMapWr  = regWr && stb.pciMapSel;
    stb.ioMapWr   = regWr && stb.ioMapSel;
    stb.pciClr    = regWr && oddWord && pciClrHit;
    stb.ioClr     = regWr && oddWord && ioClrHit;
    stb.slot      = regAddr[7:3];
  end
endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_VEC-1:0] srcLevel,
  output logic [NUM_VEC-1:0] vecOut,
  output logic [DATA_W-1:0]  rdData
);
  logic [PCI_REGS-1:0] pciEn;
  logic [IO_SRC-1:0]   ioEn;
  logic [NUM_VEC-1:0]  enVec, clrVec, levelQ, vecQ, changed, vecNext;
  logic                unusedWrLow;

  assign unusedWrLow = ^wrData[EN_BIT-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pciEn <= '0;
      ioEn  <= '0;
    end else begin
      if (stb.pciMapWr) pciEn[stb.slot[PCI_REG_IDX_W-1:0]] <= wrData[EN_BIT];
      if (stb.ioMapWr)  ioEn[stb.slot[IO_IDX_W-1:0]]       <= wrData[EN_BIT];
    end
  end

  for (genvar n = 0; n < PCI_SRC; n++) begin : g_pciGate
    assign enVec[n] = pciEn[n / PCI_PER_REG];
  end
  for (genvar k = 0; k < IO_SRC; k++) begin : g_ioGate
    assign enVec[PCI_SRC + k] = ioEn[k];
  end

  always_comb begin
    clrVec = '0;
    if (stb.pciClr) clrVec[int'(stb.slot[PCI_REG_IDX_W-1:0])] = 1'b1;
    if (stb.ioClr)  clrVec[PCI_SRC + int'(stb.slot)] = 1'b1;
  end

  assign changed = srcLevel ^ levelQ;
  assign vecNext = ~clrVec & enVec & ((changed & srcLevel) | (~changed & vecQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
      vecQ   <= '0;
    end else begin
      levelQ <= srcLevel;
      vecQ   <= vecNext;
    end
  end

  assign vecOut = vecQ;

  always_comb begin
    rdData = '0;
    if (stb.pciMapSel)
      rdData = {pciEn[stb.slot[PCI_REG_IDX_W-1:0]], pciMapLow(int'(stb.slot[PCI_REG_IDX_W-1:0]))};
    else if (stb.ioMapSel)
      rdData = {ioEn[stb.slot[IO_IDX_W-1:0]], ioMapLow(int'(stb.slot[IO_IDX_W-1:0]))};
  end
endmodule

// File: rtl/irq_slot_index.sv
module irq_slot_index
  import irq_router_pkg::*;
(
  input  logic [7:0]        devFn,
  input  logic [PIN_W-1:0]  pin,
  input  logic              onPrimary,
  output logic [LINE_W-1:0] lineIdx
);
  logic [LINE_W-1:0] primBase, secBase;
  logic [2:0]        unusedFn;

  assign unusedFn = {devFn[7], devFn[6] ^ devFn[5], devFn[2] ^ devFn[1]};
  assign primBase = devFn[0] ? LINE_W'(16) : '0;
  assign secBase  = LINE_W'({devFn[4:3], 2'b00});
  assign lineIdx  = (onPrimary ? primBase : secBase) + LINE_W'(pin);
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWr,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_VEC-1:0] srcLevel,
  output logic [NUM_VEC-1:0] vecOut,
  input  logic [7:0]         slotDevFn,
  input  logic [PIN_W-1:0]   slotPin,
  input  logic               slotPrimary,
  output logic [LINE_W-1:0]  slotLine
);
  strobe_t stb;

  irq_router_ctrl u_ctrl (
    .regWr   (regWr),
    .regAddr (regAddr),
    .stb     (stb)
  );

  irq_router_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (regWrData),
    .srcLevel (srcLevel),
    .vecOut   (vecOut),
    .rdData   (regRdData)
  );

  irq_slot_index u_slot (
    .devFn     (slotDevFn),
    .pin       (slotPin),
    .onPrimary (slotPrimary),
    .lineIdx   (slotLine)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               regWr,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdData,
  input logic [NUM_VEC-1:0] srcLevel,
  input logic [NUM_VEC-1:0] vecOut,
  input logic               slotPrimary,
  input logic [LINE_W-1:0]  slotLine
);
  p_even_word_reads_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr[2] |-> regRdData == '0);

  p_hold_without_change_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!regWr && !$past(regWr) && $stable(srcLevel)) |=> $stable(vecOut));

  p_rise_needs_level_r6: assert property (@(posedge clk) disable iff (!rstN)
    (vecOut & ~$past(vecOut) & ~$past(srcLevel)) == '0);

  p_pci_clear_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr[2] && regAddr[ADDR_W-1:6] == PCI_CLR_BASE[ADDR_W-1:6])
      |=> !vecOut[$past(regAddr[5:3])]);

  p_io_clear_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && regAddr[2] && regAddr[ADDR_W-1:8] == IO_CLR_BASE[ADDR_W-1:8] &&
     regAddr[7:0] <= IO_CLR_LAST[7:0])
      |=> !vecOut[{1'b1, $past(regAddr[7:3])}]);

  p_slot_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    slotPrimary ? (slotLine < LINE_W'(20)) : (slotLine < LINE_W'(16)));
endmodule

bind irq_router irq_router_chk u_chk (.*);

// File: tb/irq_router_tb.sv
module irq_router_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic        regWr;
  logic [15:0] regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic [47:0] srcLevel;
  logic [47:0] vecOut;
  logic [7:0]  slotDevFn;
  logic [1:0]  slotPin;
  logic        slotPrimary;
  logic [4:0]  slotLine;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  localparam logic [47:0] LVL = 48'h0008_0000_01F0;

  always #2 clk = ~clk;

  irq_router u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0; regAddr = 16'h0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic setLvl(input logic [47:0] v);
    @(negedge clk);
    srcLevel = v;
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic t_reset_values();
    logic [31:0] v;
    check("R1 vectors low after reset", 64'(vecOut), 64'h0);
    for (int g = 0; g < 8; g++) begin
      rd(16'h0C04 + 16'(8 * g), v);
      check("R2 PCI map read", 64'(v), 64'(32'h7C0 | (g << 2)));
    end
    for (int k = 0; k < 16; k++) begin
      rd(16'h1004 + 16'(8 * k), v);
      check("R2 IO map read", 64'(v), 64'(32'h7E0 + k));
    end
  endtask

  task automatic t_write_mask();
    logic [31:0] v;
    wr(16'h0C1C, 32'hFFFF_FFFF);
    rd(16'h0C1C, v);
    check("R3 all-ones write keeps low bits", 64'(v), 64'h8000_07CC);
    wr(16'h0C1C, 32'h0);
    rd(16'h0C1C, v);
    check("R3 zero write keeps low bits", 64'(v), 64'h0000_07CC);
    wr(16'h102C, 32'h7FFF_FFFF);
    rd(16'h102C, v);
    check("R3 IO low bits not writable", 64'(v), 64'h0000_07E5);
  endtask

  task automatic t_even_word();
    logic [31:0] v;
    wr(16'h0C08, 32'h8000_0000);
    rd(16'h0C0C, v);
    check("R4 even-word write ignored", 64'(v), 64'h0000_07C4);
    rd(16'h0C08, v);
    check("R4 even-word read is zero", 64'(v), 64'h0);
  endtask

  task automatic t_gating();
    wr(16'h0C0C, 32'h8000_0000);
    setLvl(LVL);
    check("R5 only group 1 passes", 64'(vecOut), 64'h0000_0000_00F0);
    wr(16'h101C, 32'h8000_0000);
    @(negedge clk);
    check("R6 enable with level high does not raise", 64'(vecOut), 64'h0000_0000_00F0);
    setLvl(LVL & ~(48'h1 << 35));
    setLvl(LVL);
    check("R5 IO line 3 follows after change", 64'(vecOut), 64'h0008_0000_00F0);
  endtask

  task automatic t_disable();
    wr(16'h0C0C, 32'h0);
    @(negedge clk);
    check("R7 disabled group forced low", 64'(vecOut), 64'h0008_0000_0000);
    wr(16'h0C0C, 32'h8000_0000);
    @(negedge clk);
    check("R6 re-enable without change stays low", 64'(vecOut), 64'h0008_0000_0000);
  endtask

  task automatic t_clear();
    setLvl(LVL & ~(48'h1 << 5));
    setLvl(LVL);
    check("R6 line 5 follows rise", 64'(vecOut), 64'h0008_0000_0020);
    wr(16'h142C, 32'h0);
    check("R8 PCI clear lowers line 5", 64'(vecOut), 64'h0008_0000_0000);
    repeat (3) @(negedge clk);
    check("R8 cleared line stays low", 64'(vecOut), 64'h0008_0000_0000);
    wr(16'h181C, 32'h0);
    check("R8 IO clear lowers line 35", 64'(vecOut), 64'h0);
    setLvl(LVL & ~(48'h1 << 5));
    setLvl(LVL);
    wr(16'h1428, 32'h0);
    check("R4 even-word clear ignored", 64'(vecOut), 64'h0000_0000_0020);
  endtask

  task automatic t_clear_wins();
    setLvl(LVL & ~(48'h1 << 6));
    @(negedge clk);
    srcLevel = LVL;
    regWr = 1'b1; regAddr = 16'h1434; regWrData = 32'h0;
    @(negedge clk);
    regWr = 1'b0; regAddr = 16'h0;
    check("R9 clear beats rising level", 64'(vecOut), 64'h0000_0000_0020);
    repeat (2) @(negedge clk);
    check("R9 stays low while level held", 64'(vecOut), 64'h0000_0000_0020);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(16'h2004, 32'hFFFF_FFFF);
    wr(16'h1084, 32'h8000_0000);
    wr(16'h1864, 32'h0);
    rd(16'h2004, v);
    check("R11 unmapped read zero", 64'(v), 64'h0);
    rd(16'h1084, v);
    check("R11 past IO map range reads zero", 64'(v), 64'h0);
    check("R11 unmapped writes leave vectors", 64'(vecOut), 64'h0000_0000_0020);
  endtask

  task automatic t_slot();
    slotPrimary = 1'b0; slotDevFn = 8'h18; slotPin = 2'd2;
    #1 check("R10 secondary devfn 0x18 pin 2", 64'(slotLine), 64'd14);
    slotDevFn = 8'hE9; slotPin = 2'd1;
    #1 check("R10 secondary devfn 0xE9 pin 1", 64'(slotLine), 64'd5);
    slotPrimary = 1'b1; slotDevFn = 8'h01; slotPin = 2'd3;
    #1 check("R10 primary odd function", 64'(slotLine), 64'd19);
    slotDevFn = 8'h1E; slotPin = 2'd0;
    #1 check("R10 primary even function", 64'(slotLine), 64'd0);
  endtask

  task automatic t_rereset();
    logic [31:0] v;
    doReset();
    @(negedge clk);
    check("R1 vectors low after second reset", 64'(vecOut), 64'h0);
    rd(16'h0C0C, v);
    check("R1 enable cleared, low bits kept", 64'(v), 64'h0000_07C4);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWr = 1'b0; regAddr = 16'h0; regWrData = 32'h0;
    srcLevel = 48'h0; slotDevFn = 8'h0; slotPin = 2'd0; slotPrimary = 1'b0;
    doReset();
    @(negedge clk);
    t_reset_values();
    t_write_mask();
    t_even_word();
    t_gating();
    t_disable();
    t_clear();
    t_clear_wins();
    t_unmapped();
    t_slot();
    t_rereset();
    finishRun();
  end
endmodule